// File: doc/BRIEF.md
# Bidirectional Latched Bus Transceiver

This block sits between two 8-bit buses, side A and side B, and moves data across in either direction through its own bank of level-sensitive storage. Each direction has three active-low controls. A direction enable and a latch enable together open or close that direction's latches. An output enable decides whether the receiving side is driven at all. While both gating strobes of a direction are low, the latches are transparent and the far side follows the near side's input. When either strobe rises, the latches close on the data that was present and then hold it.

Each side has a data-in bus, a data-out bus and a drive flag, so a chip-level pad ring can build the tri-state pins. Output gating is independent of storage. Data can therefore be captured while a side is undriven and shown later. Nothing stops both sides from driving at once: preventing that is up to the system around the block.

Top module: `bus_xcvr`

## Requirements
- R1: The A-to-B path (controls `ab_*`, input `a_in`, outputs `b_out`/`b_drive`) and the B-to-A path (controls `ba_*`, input `b_in`, outputs `a_out`/`a_drive`) are independent: no control or data change on one path alters the other path's outputs.
- R2: With `ab_en_n`, `ab_le_n` and `ab_oe_n` all low, `b_out` equals `a_in` and follows every change of `a_in`.
- R3: With `ba_en_n`, `ba_le_n` and `ba_oe_n` all low, `a_out` equals `b_in` and follows every change of `b_in`.
- R4: A rising edge of a direction's latch enable while its direction enable is low stores the input data present before the edge.
- R5: A rising edge of a direction's direction enable while its latch enable is low stores the input data present before the edge.
- R6: While either the direction enable or the latch enable of a direction is high, changes of that direction's input leave its output unchanged.
- R7: A high output enable makes that side's drive flag 0 and its data-out bus all zeros. A low output enable makes the drive flag 1 and shows the latch contents on the data-out bus.
- R8: Capture works while the output enable is high: data stored with the output disabled appears on the data-out bus once the output enable goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_in | input | W | Data arriving from side A |
| a_out | output | W | Data driven toward side A (zero when not driving) |
| a_drive | output | 1 | High when side A pins should be driven |
| b_in | input | W | Data arriving from side B |
| b_out | output | W | Data driven toward side B (zero when not driving) |
| b_drive | output | 1 | High when side B pins should be driven |
| ab_en_n | input | 1 | A-to-B direction enable, active low |
| ab_le_n | input | 1 | A-to-B latch enable, active low |
| ab_oe_n | input | 1 | Side B output enable, active low |
| ba_en_n | input | 1 | B-to-A direction enable, active low |
| ba_le_n | input | 1 | B-to-A latch enable, active low |
| ba_oe_n | input | 1 | Side A output enable, active low |

## Verification
Directed sequences cover four cases. First, data changes under an open gate, which separates transparency from a stale hold. Second, closing through the latch enable and then through the direction enable, which shows that either strobe alone captures. Third, capture with the output disabled, which separates storage from output gating. Fourth, activity on one path while the other path holds, which exposes cross-coupling. A seeded random phase then alternates between changing only data and changing only controls. It compares every output against a bench model of the open/closed gate, and it reports each cycle in which both sides drive at once.

// File: rtl/xcvr_pkg.sv
// Shared helpers for the bidirectional latched bus transceiver.
// Assumes: all gating controls are active low.
package xcvr_pkg;

    localparam int XCVR_DEFAULT_W = 8;

    // A direction's latches pass data only while both strobes are low.
    function automatic logic gate_open(input logic en_n, input logic le_n);
        return !en_n && !le_n;
    endfunction

endpackage

// File: rtl/xcvr_latch_bank.sv
// One direction's bank of level-sensitive storage, one latch per bit.
// Transparent while both active-low strobes are low; holds otherwise.
// Assumes: input data is stable for a setup interval before either strobe rises.
module xcvr_latch_bank
    import xcvr_pkg::*;
#(
    parameter int W = XCVR_DEFAULT_W
) (
    input  logic         en_n,
    input  logic         le_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic open_w;

    // Combine the two strobes into the single latch gate.
    assign open_w = gate_open(en_n, le_n);

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic bit_q;

        // Per-bit storage: follow d while open, keep value while closed.
        always_latch begin
            if (open_w) bit_q = d[i];
        end

        assign q[i] = bit_q;
    end

endmodule

// File: rtl/xcvr_drive_stage.sv
// Output gating for one side: raises the drive flag and presents stored data
// when the active-low output enable is low, else parks the bus at zero.
// Assumes: the pad ring builds tri-state pins from dout and drive.
module xcvr_drive_stage #(
    parameter int W = 8
) (
    input  logic         oe_n,
    input  logic [W-1:0] q,
    output logic         drive,
    output logic [W-1:0] dout
);

    // Gate the stored value onto the outgoing bus.
    always_comb begin
        drive = !oe_n;
        dout  = drive ? q : '0;
    end

endmodule

// File: rtl/bus_xcvr.sv
// Bidirectional latched bus transceiver core. Two independent paths, each a
// latch bank followed by an output gate, carry A data to B and B data to A.
// Assumes: the surrounding system never enables both sides' drive at once.
module bus_xcvr
    import xcvr_pkg::*;
#(
    parameter int W = XCVR_DEFAULT_W
) (
    input  logic [W-1:0] a_in,
    output logic [W-1:0] a_out,
    output logic         a_drive,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] b_out,
    output logic         b_drive,
    input  logic         ab_en_n,
    input  logic         ab_le_n,
    input  logic         ab_oe_n,
    input  logic         ba_en_n,
    input  logic         ba_le_n,
    input  logic         ba_oe_n
);

    logic [W-1:0] ab_q;
    logic [W-1:0] ba_q;

    // A-to-B storage.
    xcvr_latch_bank #(.W(W)) u_ab_bank (
        .en_n (ab_en_n),
        .le_n (ab_le_n),
        .d    (a_in),
        .q    (ab_q)
    );

    // B side output gate.
    xcvr_drive_stage #(.W(W)) u_b_drv (
        .oe_n  (ab_oe_n),
        .q     (ab_q),
        .drive (b_drive),
        .dout  (b_out)
    );

    // B-to-A storage.
    xcvr_latch_bank #(.W(W)) u_ba_bank (
        .en_n (ba_en_n),
        .le_n (ba_le_n),
        .d    (b_in),
        .q    (ba_q)
    );

    // A side output gate.
    xcvr_drive_stage #(.W(W)) u_a_drv (
        .oe_n  (ba_oe_n),
        .q     (ba_q),
        .drive (a_drive),
        .dout  (a_out)
    );

endmodule

// File: rtl/bus_xcvr_chk.sv
// Checker for bus_xcvr: port-level rules on transparency and output parking.
// Assumes: the block is purely combinational plus latches, so checks are
// immediate and evaluated whenever their inputs settle.
module bus_xcvr_chk #(
    parameter int W = 8
) (
    input logic [W-1:0] a_in,
    input logic [W-1:0] a_out,
    input logic         a_drive,
    input logic [W-1:0] b_in,
    input logic [W-1:0] b_out,
    input logic         b_drive,
    input logic         ab_en_n,
    input logic         ab_le_n,
    input logic         ab_oe_n,
    input logic         ba_en_n,
    input logic         ba_le_n,
    input logic         ba_oe_n
);

    // Transparency and parking checks for both paths.
    always_comb begin
        if (!ab_en_n && !ab_le_n && !ab_oe_n)
            p_follow_ab_r2: assert (b_out == a_in)
                else $error("b_out does not follow a_in while open");
        if (!ba_en_n && !ba_le_n && !ba_oe_n)
            p_follow_ba_r3: assert (a_out == b_in)
                else $error("a_out does not follow b_in while open");
        if (ab_oe_n)
            p_park_b_r7: assert (!b_drive && b_out == '0)
                else $error("side B not parked while disabled");
        if (ba_oe_n)
            p_park_a_r7: assert (!a_drive && a_out == '0)
                else $error("side A not parked while disabled");
    end

endmodule

bind bus_xcvr bus_xcvr_chk #(.W(W)) u_chk (.*);

// File: tb/bus_xcvr_bench.sv
// Self-checking bench for bus_xcvr: directed corners, then seeded random.
module bus_xcvr_bench;

    localparam int W = 8;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic [W-1:0] a_in = '0, b_in = '0;
    logic [W-1:0] a_out, b_out;
    logic         a_drive, b_drive;
    logic ab_en_n = 1'b1, ab_le_n = 1'b1, ab_oe_n = 1'b1;
    logic ba_en_n = 1'b1, ba_le_n = 1'b1, ba_oe_n = 1'b1;

    int n_tests = 0, n_fail = 0, n_overlap = 0;
    bit done = 1'b0;
    logic [W-1:0] m_ab = '0, m_ba = '0;   // bench model of stored data

    bus_xcvr #(.W(W)) u_bus_xcvr (.*);

    // Report cycles in which both sides drive at once.
    always @(posedge clk) if (a_drive && b_drive) n_overlap++;

    task automatic chk(input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // ctl = {ab_en_n, ab_le_n, ab_oe_n, ba_en_n, ba_le_n, ba_oe_n}.
    // Caller changes data or closes a gate, never both in one step.
    task automatic step(input string req, input logic [W-1:0] ai,
                        input logic [W-1:0] bi, input logic [5:0] ctl);
        @(negedge clk);
        a_in = ai; b_in = bi;
        {ab_en_n, ab_le_n, ab_oe_n, ba_en_n, ba_le_n, ba_oe_n} = ctl;
        #2;
        if (!ab_en_n && !ab_le_n) m_ab = ai;
        if (!ba_en_n && !ba_le_n) m_ba = bi;
        chk(req, "b_out", b_out, ab_oe_n ? '0 : m_ab);
        chk(req, "b_drive", {7'd0, b_drive}, {7'd0, !ab_oe_n});
        chk(req, "a_out", a_out, ba_oe_n ? '0 : m_ba);
        chk(req, "a_drive", {7'd0, a_drive}, {7'd0, !ba_oe_n});
    endtask

    initial begin
        int unsigned seed;
        logic [5:0] c;
        logic [W-1:0] av, bv;
        seed = $urandom(32'd2718);
        // Idle: both sides parked (R7).
        step("R7", 8'h00, 8'h00, 6'b111_111);
        // R2 open A-to-B with B driven, then data follows.
        step("R2", 8'hA5, 8'h3C, 6'b000_111);
        step("R2", 8'h5A, 8'h3C, 6'b000_111);
        // R4 close with latch enable, then input changes are ignored (R6).
        step("R4", 8'h5A, 8'h3C, 6'b010_111);
        step("R6", 8'hFF, 8'h3C, 6'b010_111);
        // R5 capture via direction enable edge.
        step("R6", 8'hFF, 8'h3C, 6'b110_111);
        step("R6", 8'h81, 8'h3C, 6'b100_111);
        step("R2", 8'h81, 8'h3C, 6'b000_111);
        step("R5", 8'h81, 8'h3C, 6'b100_111);
        step("R5", 8'h00, 8'h3C, 6'b100_111);
        // R8 capture with B undriven, then reveal.
        step("R7", 8'hC3, 8'h3C, 6'b001_111);
        step("R8", 8'hC3, 8'h3C, 6'b011_111);
        step("R8", 8'h11, 8'h3C, 6'b011_111);
        step("R8", 8'h11, 8'h3C, 6'b010_111);
        // R3 open B-to-A with A driven while A-to-B holds (R1).
        step("R3", 8'h11, 8'h96, 6'b111_000);
        step("R3", 8'h11, 8'h69, 6'b111_000);
        step("R1", 8'h22, 8'h69, 6'b110_000);
        step("R4", 8'h22, 8'h69, 6'b110_010);
        step("R6", 8'h22, 8'hE7, 6'b110_010);
        // R1 A-to-B transparent while B-to-A holds.
        step("R1", 8'h22, 8'hE7, 6'b001_010);
        step("R1", 8'h44, 8'hE7, 6'b001_010);
        step("R5", 8'h44, 8'h24, 6'b101_000);
        step("R5", 8'h44, 8'h24, 6'b101_100);
        step("R6", 8'h44, 8'hDB, 6'b101_100);
        // Random: alternate data-only and control-only steps (R6 model).
        c = 6'b111_111; av = a_in; bv = b_in;
        for (int k = 0; k < 400; k++) begin
            if ($urandom % 2 == 0) begin
                av = W'($urandom); bv = W'($urandom);
            end else begin
                c = 6'($urandom);
            end
            step("R6", av, bv, c);
        end
        if (n_overlap != 0)
            $display("[TB] note: both sides driven in %0d cycles", n_overlap);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog.
    initial begin
        #1_000_000;
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule